// File: doc/BRIEF.md
# Watchdog Down-Counter Timer

This block is a 32-bit countdown timer kept as two 16-bit halves behind a small register port. While it runs, the count drops by one on every tick of a fixed-rate timebase. A prescaler divides the system clock by `TICK_DIV` to produce that timebase, so the default of 40 turns a 200 MHz clock into a 5 MHz tick. Software starts and stops the timer with self-clearing command bits. When the count passes through zero it reloads itself to all ones, keeps counting and sets the timer-complete status bit.

The block also owns the interrupt status and mask registers for its controller. Other parts of the controller report events as one-cycle pulses on `evt_set`, one bit per status bit. The interrupt line is high whenever an enabled status bit is set. Software clears status bits by writing ones to them. Reads return live values, so the count registers always show the current count.

Top module: `wdog_countdown`

## Requirements
- R1: After reset the command register (address 0) reads 0x0001 (stopped), the mask (address 1), the status (address 2) and both count halves (address 3 low, address 4 high) read 0, `irq` is low and the count does not change.
- R2: Reading address 3 returns bits 15:0 of the live count and reading address 4 returns bits 31:16; a write to either address replaces only that half.
- R3: While running, the count decrements once every `TICK_DIV` clock cycles; the first decrement lands `TICK_DIV` clock edges after the edge that took the start command or a count write.
- R4: Command bit 0 written as 1 stops the timer and freezes the count; command bit 1 written as 1 starts it. The command register reads back bit 0 = stopped and bit 1 = running, with exactly one of the two set. If both bits are written together, the start takes effect.
- R5: A tick that arrives while the count is 0 reloads the count to 0xFFFF_FFFF and sets status bit 7 (timer complete), and counting continues from there.
- R6: Writing either count half while the timer runs restarts the tick period, so the newly written value is held for a full `TICK_DIV` cycles.
- R7: `irq` is high exactly when the mask AND the status is nonzero; bit 15 of a mask write is dropped and reads back as 0.
- R8: Writing the status register clears each bit that is written as 1; bits written as 0 keep their value.
- R9: A 1 on `evt_set[i]` sets status bit i at the next edge; a set and a write-1-to-clear of the same bit in the same cycle leave the bit set.
- R10: Writes to addresses 5 to 7 change no register, and reads there return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe for this cycle |
| reg_addr | input | 3 | Register address for read and write |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr`, same cycle |
| evt_set | input | 16 | One-cycle pulses that set the matching status bits |
| irq | output | 1 | Interrupt request: OR of the masked status bits |

## Verification
Reads are combinational, so every register write can be read back at the falling edge that follows its capturing edge. `irq` follows the mask and status registers in the same way, one edge after the write or event. A count of V that is written or started at edge E reads V-n after edge E+n·`TICK_DIV`, and it wraps to all ones with status bit 7 set at edge E+(V+1)·`TICK_DIV`. The bench drives all inputs at falling edges, advances a requirement-level model once per rising edge, and compares reads and `irq` at the next falling edge. The directed cases check at exactly `TICK_DIV`-1 and `TICK_DIV` edges after each restart, so that a timing error of one cycle shows up.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int REG_W      = 16;
    localparam int ADDR_W     = 3;
    localparam int TC_BIT     = 7;
    localparam int CMD_STOP   = 0;
    localparam int CMD_START  = 1;

    typedef enum logic [ADDR_W-1:0] {
        ADR_CMD    = 3'd0,
        ADR_MASK   = 3'd1,
        ADR_STAT   = 3'd2,
        ADR_CNT_LO = 3'd3,
        ADR_CNT_HI = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic run;
        logic stop;
    } cmd_st_t;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int DIV = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    typedef struct packed {
        logic [PW-1:0] pre;
    } pre_st_t;

    pre_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = run && (st_q.pre == LAST);
        if (restart || !run) begin
            st_d.pre = '0;
        end else if (tick) begin
            st_d.pre = '0;
        end else begin
            st_d.pre = st_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int HW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic [1:0]      half_wr,
    input  logic [HW-1:0]   wdata,
    output logic [2*HW-1:0] count,
    output logic            wrap
);
    localparam int CW = 2 * HW;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        wrap = 1'b0;
        if (|half_wr) begin
            for (int h = 0; h < 2; h++) begin
                if (half_wr[h]) begin
                    st_d.cnt[h*HW +: HW] = wdata;
                end
            end
        end else if (tick) begin
            if (st_q.cnt == '0) begin
                st_d.cnt = '1;
                wrap     = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    assign count = st_q.cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/wdog_irq_regs.sv
module wdog_irq_regs #(
    parameter int W  = 16,
    parameter int TC = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mask_wr,
    input  logic         stat_wr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] evt_set,
    input  logic         tc_set,
    output logic [W-1:0] mask,
    output logic [W-1:0] stat,
    output logic         irq
);
    localparam logic [W-1:0] TC_VEC    = W'(1) << TC;
    localparam logic [W-1:0] MASK_KEEP = {1'b0, {(W-1){1'b1}}};

    typedef struct packed {
        logic [W-1:0] mask;
        logic [W-1:0] stat;
    } irq_st_t;

    irq_st_t      st_d, st_q;
    logic [W-1:0] set_vec;
    logic [W-1:0] clr_vec;

    always_comb begin
        st_d    = st_q;
        set_vec = evt_set | (tc_set ? TC_VEC : '0);
        clr_vec = stat_wr ? wdata : '0;
        if (mask_wr) begin
            st_d.mask = wdata & MASK_KEEP;
        end
        st_d.stat = (st_q.stat & ~clr_vec) | set_vec;
    end

    assign mask = st_q.mask;
    assign stat = st_q.stat;
    assign irq  = |(st_q.mask & st_q.stat);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown
    import wdog_pkg::*;
#(
    parameter int TICK_DIV = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [REG_W-1:0]  evt_set,
    output logic              irq
);
    localparam int CNT_W = 2 * REG_W;

    cmd_st_t           cmd_d, cmd_q;
    logic              wr_cmd, wr_mask, wr_stat;
    logic [1:0]        half_wr;
    logic              start_req, stop_req, restart;
    logic              tick_w, uf_w;
    logic              run_w, stop_w;
    logic [CNT_W-1:0]  cnt_w;
    logic [REG_W-1:0]  mask_w, stat_w;

    assign wr_cmd     = reg_we && (reg_addr == ADR_CMD);
    assign wr_mask    = reg_we && (reg_addr == ADR_MASK);
    assign wr_stat    = reg_we && (reg_addr == ADR_STAT);
    assign half_wr[0] = reg_we && (reg_addr == ADR_CNT_LO);
    assign half_wr[1] = reg_we && (reg_addr == ADR_CNT_HI);

    assign start_req = wr_cmd && reg_wdata[CMD_START];
    assign stop_req  = wr_cmd && reg_wdata[CMD_STOP];
    assign restart   = start_req || (|half_wr);

    // Command state: stop handled first, start last so it wins.
    always_comb begin
        cmd_d = cmd_q;
        if (stop_req) begin
            cmd_d.run  = 1'b0;
            cmd_d.stop = 1'b1;
        end
        if (start_req) begin
            cmd_d.run  = 1'b1;
            cmd_d.stop = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '{run: 1'b0, stop: 1'b1};
        end else begin
            cmd_q <= cmd_d;
        end
    end

    assign run_w  = cmd_q.run;
    assign stop_w = cmd_q.stop;

    wdog_prescaler #(.DIV(TICK_DIV)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_w),
        .restart (restart),
        .tick    (tick_w)
    );

    wdog_counter #(.HW(REG_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_w),
        .half_wr (half_wr),
        .wdata   (reg_wdata),
        .count   (cnt_w),
        .wrap    (uf_w)
    );

    wdog_irq_regs #(.W(REG_W), .TC(TC_BIT)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .mask_wr (wr_mask),
        .stat_wr (wr_stat),
        .wdata   (reg_wdata),
        .evt_set (evt_set),
        .tc_set  (uf_w),
        .mask    (mask_w),
        .stat    (stat_w),
        .irq     (irq)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADR_CMD: begin
                reg_rdata[CMD_STOP]  = cmd_q.stop;
                reg_rdata[CMD_START] = cmd_q.run;
            end
            ADR_MASK:   reg_rdata = mask_w;
            ADR_STAT:   reg_rdata = stat_w;
            ADR_CNT_LO: reg_rdata = cnt_w[REG_W-1:0];
            ADR_CNT_HI: reg_rdata = cnt_w[CNT_W-1:REG_W];
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdog_countdown_chk.sv
module wdog_countdown_chk #(
    parameter int W  = 16,
    parameter int TC = 7
) (
    input logic           clk,
    input logic           rst_n,
    input logic           tick,
    input logic           run,
    input logic           stop,
    input logic [1:0]     cnt_wr,
    input logic [2*W-1:0] cnt,
    input logic           uf,
    input logic           mask_wr,
    input logic           stat_wr,
    input logic [W-1:0]   wdata,
    input logic [W-1:0]   evt,
    input logic [W-1:0]   mask,
    input logic [W-1:0]   stat
);
    // R3
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && cnt_wr == 2'b00) |=> cnt == $past(cnt));

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_wr == 2'b00 && cnt != '0) |=> cnt == $past(cnt) - 1'b1);

    // R5
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_wr == 2'b00 && cnt == '0) |=> (cnt == '1) && stat[TC]);

    // R4
    stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !tick);

    // R4
    cmd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({run, stop}) == 1);

    // R7
    mask_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> !mask[W-1]);

    // R9
    evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((stat & $past(evt)) == $past(evt)));

    // R8
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && evt == '0 && !uf) |=> ((stat & $past(wdata)) == '0));
endmodule

bind wdog_countdown wdog_countdown_chk #(
    .W  (wdog_pkg::REG_W),
    .TC (wdog_pkg::TC_BIT)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_w),
    .run     (run_w),
    .stop    (stop_w),
    .cnt_wr  (half_wr),
    .cnt     (cnt_w),
    .uf      (uf_w),
    .mask_wr (wr_mask),
    .stat_wr (wr_stat),
    .wdata   (reg_wdata),
    .evt     (evt_set),
    .mask    (mask_w),
    .stat    (stat_w)
);

// File: tb/wdog_countdown_bench.sv
`timescale 1ns/1ps
module wdog_countdown_bench;
    localparam int DIV = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [15:0] evt_set = '0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    // Requirement-level model
    bit          m_run, m_stop;
    int          m_pre;
    logic [31:0] m_cnt;
    logic [15:0] m_mask, m_stat;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdog_countdown #(.TICK_DIV(DIV)) u_wdog_countdown (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_set(evt_set), .irq(irq)
    );

    function automatic logic [15:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: m_read = {14'd0, m_run, m_stop};
            3'd1: m_read = m_mask;
            3'd2: m_read = m_stat;
            3'd3: m_read = m_cnt[15:0];
            3'd4: m_read = m_cnt[31:16];
            default: m_read = 16'h0000;
        endcase
    endfunction

    task automatic chk_rd(input logic [2:0] a, input logic [15:0] exp, input string tag);
        reg_we = 1'b0;
        reg_addr = a;
        #1;
        n_chk++;
        if (reg_rdata !== exp) begin
            n_bad++;
            $display("FAIL %s addr %0d actual %h expected %h", tag, a, reg_rdata, exp);
        end
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        n_chk++;
        if (irq !== exp) begin
            n_bad++;
            $display("FAIL %s irq actual %b expected %b", tag, irq, exp);
        end
    endtask

    // One clock: inputs driven now (falling-edge region), model advanced at the edge.
    task automatic step(input bit we, input logic [2:0] a, input logic [15:0] d,
                        input logic [15:0] ev);
        bit          n_run, n_stop, tk, uf, restart;
        int          n_pre;
        logic [31:0] n_cnt;
        logic [15:0] n_mask, n_stat;
        reg_we = we; reg_addr = a; reg_wdata = d; evt_set = ev;
        n_run = m_run; n_stop = m_stop; n_cnt = m_cnt; n_mask = m_mask; uf = 1'b0;
        if (we && a == 3'd0 && d[0]) begin n_run = 1'b0; n_stop = 1'b1; end
        if (we && a == 3'd0 && d[1]) begin n_run = 1'b1; n_stop = 1'b0; end
        tk = m_run && (m_pre == DIV - 1);
        restart = we && ((a == 3'd0 && d[1]) || a == 3'd3 || a == 3'd4);
        if (we && a == 3'd3) n_cnt[15:0] = d;
        else if (we && a == 3'd4) n_cnt[31:16] = d;
        else if (tk) begin
            if (m_cnt == 32'd0) begin n_cnt = 32'hFFFF_FFFF; uf = 1'b1; end
            else n_cnt = m_cnt - 32'd1;
        end
        if (restart || !m_run || tk) n_pre = 0; else n_pre = m_pre + 1;
        if (we && a == 3'd1) n_mask = d & 16'h7FFF;
        n_stat = (m_stat & ~((we && a == 3'd2) ? d : 16'h0000)) | ev | (uf ? 16'h0080 : 16'h0000);
        @(posedge clk);
        m_run = n_run; m_stop = n_stop; m_pre = n_pre; m_cnt = n_cnt;
        m_mask = n_mask; m_stat = n_stat;
        @(negedge clk);
        reg_we = 1'b0; evt_set = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 3'd0, 16'h0, 16'h0);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            if (cyc > 150000) begin
                n_chk++;
                n_bad++;
                $display("FAIL watchdog expired at cycle %0d", cyc);
                finish_run();
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_run = 1'b0; m_stop = 1'b1; m_pre = 0; m_cnt = '0; m_mask = '0; m_stat = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk_rd(3'd0, 16'h0001, "R1");
        chk_rd(3'd1, 16'h0000, "R1");
        chk_rd(3'd2, 16'h0000, "R1");
        chk_rd(3'd3, 16'h0000, "R1");
        chk_rd(3'd4, 16'h0000, "R1");
        chk_irq(1'b0, "R1");
        idle(DIV + 3);
        chk_rd(3'd3, 16'h0000, "R1");

        // R10 unmapped address
        step(1'b1, 3'd6, 16'hABCD, 16'h0);
        chk_rd(3'd6, 16'h0000, "R10");
        chk_rd(3'd0, 16'h0001, "R10");
        chk_rd(3'd1, 16'h0000, "R10");

        // R2 half writes while stopped, R4 stopped holds
        step(1'b1, 3'd3, 16'h0002, 16'h0);
        step(1'b1, 3'd4, 16'h0000, 16'h0);
        chk_rd(3'd3, 16'h0002, "R2");
        chk_rd(3'd4, 16'h0000, "R2");
        idle(2 * DIV);
        chk_rd(3'd3, 16'h0002, "R4");

        // R3 start and first decrement timing
        step(1'b1, 3'd1, 16'h0080, 16'h0);
        step(1'b1, 3'd0, 16'h0002, 16'h0);
        chk_rd(3'd0, 16'h0002, "R4");
        idle(DIV - 1);
        chk_rd(3'd3, 16'h0002, "R3");
        idle(1);
        chk_rd(3'd3, 16'h0001, "R3");
        idle(DIV);
        chk_rd(3'd3, 16'h0000, "R3");
        chk_rd(3'd2, 16'h0000, "R5");
        chk_irq(1'b0, "R7");

        // R5 underflow reload
        idle(DIV);
        chk_rd(3'd3, 16'hFFFF, "R5");
        chk_rd(3'd4, 16'hFFFF, "R5");
        chk_rd(3'd2, 16'h0080, "R5");
        chk_irq(1'b1, "R7");

        // R8 write-1-to-clear
        step(1'b1, 3'd2, 16'h0000, 16'h0);
        chk_rd(3'd2, 16'h0080, "R8");
        step(1'b1, 3'd2, 16'h0080, 16'h0);
        chk_rd(3'd2, 16'h0000, "R8");
        chk_irq(1'b0, "R8");
        idle(DIV - 2);
        chk_rd(3'd3, 16'hFFFE, "R5");

        // R4 stop freezes, both bits start
        step(1'b1, 3'd0, 16'h0001, 16'h0);
        chk_rd(3'd0, 16'h0001, "R4");
        idle(3 * DIV);
        chk_rd(3'd3, 16'hFFFE, "R4");
        step(1'b1, 3'd0, 16'h0003, 16'h0);
        chk_rd(3'd0, 16'h0002, "R4");

        // R6 write while running restarts period
        idle(DIV / 2);
        step(1'b1, 3'd3, 16'h0009, 16'h0);
        idle(DIV - 1);
        chk_rd(3'd3, 16'h0009, "R6");
        idle(1);
        chk_rd(3'd3, 16'h0008, "R6");
        chk_rd(3'd4, 16'hFFFF, "R6");

        // R9 set beats same-cycle clear, events set bits
        step(1'b1, 3'd2, 16'h0008, 16'h0008);
        chk_rd(3'd2, 16'h0008, "R9");
        step(1'b0, 3'd0, 16'h0000, 16'h8000);
        chk_rd(3'd2, 16'h8008, "R9");
        chk_irq(1'b0, "R7");
        step(1'b1, 3'd1, 16'hFFFF, 16'h0);
        chk_rd(3'd1, 16'h7FFF, "R7");
        chk_irq(1'b1, "R7");
        step(1'b1, 3'd2, 16'hFFFF, 16'h0);
        chk_rd(3'd2, 16'h0000, "R8");
        chk_irq(1'b0, "R7");

        // Random phase against the model (R2 R3 R7 R8 R9)
        for (int i = 0; i < 3000; i++) begin
            int unsigned r = $urandom_range(0, 999);
            logic [2:0]  a = 3'($urandom_range(0, 7));
            logic [15:0] d = 16'($urandom);
            logic [15:0] ev = ($urandom_range(0, 15) == 0) ? (16'h1 << $urandom_range(0, 15)) : 16'h0;
            if (r < 8) begin
                step(1'b1, 3'd3, 16'($urandom_range(0, 3)), ev);
            end else if (r < 12) begin
                step(1'b1, 3'd4, 16'h0000, ev);
            end else if (r < 16) begin
                step(1'b1, 3'd0, 16'($urandom_range(0, 3)), ev);
            end else if (r < 60) begin
                if (a == 3'd3 || a == 3'd4 || a == 3'd0) a = 3'd2;
                step(1'b1, a, d, ev);
            end else begin
                step(1'b0, 3'd0, 16'h0, ev);
            end
            chk_irq(|(m_mask & m_stat), "R7");
            begin
                logic [2:0] ra = 3'($urandom_range(0, 7));
                chk_rd(ra, m_read(ra), "R2");
            end
        end

        finish_run();
    end
endmodule